// File: doc/BRIEF.md
# Serial Register Port with Ready Status

This block is the serial control port of a converter front end. A host selects it with an active-low chip select and clocks 8-bit commands and data MSB first. Through it the host reaches eight registers: mode, configuration, offset and gain words of 24 bits, a read-only 24-bit result word, and three 8-bit registers for status, identity and general-purpose outputs. All pin inputs pass through two-stage synchronizers into the system clock domain. Edges of the serial clock are found by comparing successive synchronized samples.

The conversion sequencer writes each new result through a one-cycle update port. That update clears the ready flag. The flag is set again when a host finishes reading the result word. While the host holds chip select low and no read data is being shifted, the shared data-out line carries the ready flag, so the host can poll it. The status byte holds an optional parity bit over the result. In one mode bit setting, the status byte follows every result read in the same frame.

A separate sync input holds the filter in reset and forces the data line high while it is low. If it stays low for long enough, the block signals power-down.

Top module: `spi_regfile_ctrl`

## Requirements
- R1: After reset the mode word is 0x080060, the configuration word is 0x000117, offset is 0x800000, gain is 0x555555, the status byte reads 0x80, and all general-purpose outputs, the bridge switch, power-down and filter reset are inactive.
- R2: A command byte has bit 7 = 0, bit 6 = 1 for a read or 0 for a write, bits 5:3 = register index and bits 2:0 = 0. Indices are: 0 status, 1 mode, 2 configuration, 3 result, 4 identity, 5 outputs, 6 offset, 7 gain. The command is followed by one data byte for indices 0, 4 and 5 and by three bytes for the others. DIN is sampled on the rising serial clock edge and DOUT changes after the falling edge, MSB first. A command with bit 7 set, or with bits 2:0 not zero, is ignored for the rest of the frame.
- R3: DOUT enable is off while chip select is high. While chip select is low and no read data is being shifted, DOUT carries the ready flag (status bit 7, 0 = new result).
- R4: A result update stores the 24-bit result and the 4-bit channel (status bits 3:0) and the error flag (status bit 6), and clears status bit 7. The no-reference flag (status bit 5) is stored only when configuration bit 6 is 1.
- R5: Status bit 7 is set when the last bit of a result read has been clocked. If a result update falls in that same cycle, the update wins and the bit stays 0.
- R6: Status bit 4 is 1 when mode bit 13 is 1 and the result word holds an odd number of ones; otherwise it is 0.
- R7: When mode bit 20 is 1, a result read returns 32 bits: the 24-bit result followed by the status byte as it stood at the end of the command byte.
- R8: Writes to indices 0, 3 and 4 change nothing. The identity register reads the ID_VALUE parameter.
- R9: Reserved bits are stored as zero whatever is written: mode bits 14 and 12; configuration bits 22, 21, 19:16 and 5; output register bit 7.
- R10: Offset and gain writes take effect only while mode bits 23:21 are 010 or 011. Otherwise they are dropped.
- R11: In the output register, bit 6 drives the bridge switch. Bit 5 enables pins 3 and 2, and bit 4 enables pins 1 and 0. Bits 3:0 give the pin values. A read returns the sensed pin level in place of bits 3:0 for enabled pins.
- R12: While the synchronized sync input is low, filter reset is asserted and DOUT is forced to 1. After PD_CYCLES consecutive low cycles, power-down is asserted. Power-down is released as soon as the input is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles high |
| din | input | 1 | Serial data from host |
| syncN | input | 1 | Sync / power-down request, active low |
| resWr | input | 1 | One-cycle result update strobe |
| resData | input | 24 | New conversion result |
| resChan | input | 4 | Channel tag of the result |
| resErr | input | 1 | Error flag of the result |
| resNoRef | input | 1 | Reference-missing flag of the result |
| gpioIn | input | 4 | Sensed levels of the general-purpose pins |
| doutVal | output | 1 | Serial data / ready line value |
| doutOe | output | 1 | Output enable of the data line |
| modeReg | output | 24 | Mode word |
| cfgReg | output | 24 | Configuration word |
| offsetReg | output | 24 | Offset calibration word |
| gainReg | output | 24 | Gain calibration word |
| gpoVal | output | 4 | General-purpose pin values |
| gpoOe | output | 4 | General-purpose pin enables |
| bridgeSw | output | 1 | Bridge switch control |
| filterRst | output | 1 | Filter held in reset |
| powerDown | output | 1 | Power-down request |

## Verification
The ready flag has two sources that can act in the same clock cycle: the sequencer's update port clears it, and the completion of a result read sets it. The bench places a result update exactly in the cycle where the final rising serial clock edge of a result read is seen after synchronization. It then checks three things: the read returned the old snapshot, a following status read shows the flag still cleared, and the new result is in place. A second overlap occurs when the sync input drops while chip select is low and the ready flag is 0. The bench judges it by DOUT going high on the enabled line.

// File: rtl/spi_regfile_pkg.sv
package spi_regfile_pkg;

  localparam int REG_W = 24;
  localparam int GPO_N = 4;
  localparam int TX_W  = 32;

  typedef enum logic [2:0] {
    A_STAT = 3'd0,
    A_MODE = 3'd1,
    A_CFG  = 3'd2,
    A_DATA = 3'd3,
    A_ID   = 3'd4,
    A_GPO  = 3'd5,
    A_OFS  = 3'd6,
    A_GAIN = 3'd7
  } regAddrT;

  localparam logic [REG_W-1:0] MODE_RST = 24'h080060;
  localparam logic [REG_W-1:0] CFG_RST  = 24'h000117;
  localparam logic [REG_W-1:0] OFS_RST  = 24'h800000;
  localparam logic [REG_W-1:0] GAIN_RST = 24'h555555;

  // writable-bit masks (reserved bits forced to zero)
  localparam logic [REG_W-1:0] MODE_KEEP = 24'hFFAFFF;
  localparam logic [REG_W-1:0] CFG_KEEP  = 24'h90FFDF;
  localparam logic [7:0]       GPO_KEEP  = 8'h7F;

  typedef struct packed {
    logic             loadTx;
    logic             shiftTx;
    logic             wrEn;
    logic             dataRdDone;
    logic             readActive;
    logic             syncLow;
    regAddrT          addr;
    logic [REG_W-1:0] wrData;
  } ctrlStrobeT;

  function automatic logic isNarrow(regAddrT a);
    return (a == A_STAT) || (a == A_ID) || (a == A_GPO);
  endfunction

endpackage

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import spi_regfile_pkg::*;
#(
  parameter int PD_CYCLES = 4080
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csN,
  input  logic       sclk,
  input  logic       din,
  input  logic       syncN,
  input  logic       datusEn,
  output ctrlStrobeT strb,
  output logic       csActive,
  output logic       powerDown
);

  localparam int PDW = $clog2(PD_CYCLES + 1);
  localparam logic [PDW-1:0] PD_LIM = PDW'(PD_CYCLES);

  typedef enum logic [1:0] {F_CMD, F_WR, F_RD, F_SKIP} frameStT;

  logic csM, csS, sckM, sckS, sckP, dinM, dinS, synM, synS;
  frameStT st;
  logic [5:0] bitCnt;
  logic [6:0] cmdSh;
  logic [22:0] wrSh;
  regAddrT addrQ;
  logic [PDW-1:0] pdCnt;

  logic sckRise, sckFall, cmdOk, lastBit;
  logic [7:0] cmdNext;
  logic [5:0] wrLen, rdLen, curLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csM <= 1'b1; csS <= 1'b1;
      sckM <= 1'b1; sckS <= 1'b1; sckP <= 1'b1;
      dinM <= 1'b0; dinS <= 1'b0;
      synM <= 1'b1; synS <= 1'b1;
    end else begin
      csM <= csN;   csS <= csM;
      sckM <= sclk; sckS <= sckM; sckP <= sckS;
      dinM <= din;  dinS <= dinM;
      synM <= syncN; synS <= synM;
    end
  end

  assign sckRise = sckS & ~sckP;
  assign sckFall = ~sckS & sckP;
  assign cmdNext = {cmdSh, dinS};
  assign cmdOk   = ~cmdNext[7] & (cmdNext[2:0] == 3'b000);
  assign wrLen   = isNarrow(addrQ) ? 6'd8 : 6'd24;
  assign rdLen   = ((addrQ == A_DATA) && datusEn) ? 6'd32 : wrLen;
  assign curLen  = (st == F_RD) ? rdLen : wrLen;
  assign lastBit = (bitCnt == curLen - 6'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      st <= F_CMD;
      bitCnt <= '0;
      cmdSh <= '0;
      wrSh <= '0;
      addrQ <= A_STAT;
    end else if (csS) begin
      st <= F_CMD;
      bitCnt <= '0;
    end else if (sckRise) begin
      case (st)
        F_CMD: begin
          cmdSh <= cmdNext[6:0];
          if (bitCnt == 6'd7) begin
            bitCnt <= '0;
            addrQ <= regAddrT'(cmdNext[5:3]);
            st <= !cmdOk ? F_SKIP : (cmdNext[6] ? F_RD : F_WR);
          end else begin
            bitCnt <= bitCnt + 6'd1;
          end
        end
        F_WR: begin
          wrSh <= {wrSh[21:0], dinS};
          if (lastBit) st <= F_SKIP;
          else bitCnt <= bitCnt + 6'd1;
        end
        F_RD: begin
          if (lastBit) st <= F_SKIP;
          else bitCnt <= bitCnt + 6'd1;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strb = '0;
    strb.addr       = (st == F_CMD) ? regAddrT'(cmdNext[5:3]) : addrQ;
    strb.loadTx     = ~csS & sckRise & (st == F_CMD) & (bitCnt == 6'd7) & cmdOk & cmdNext[6];
    strb.shiftTx    = ~csS & sckFall & (st == F_RD);
    strb.wrEn       = ~csS & sckRise & (st == F_WR) & lastBit;
    strb.wrData     = {wrSh, dinS};
    strb.dataRdDone = ~csS & sckRise & (st == F_RD) & lastBit & (addrQ == A_DATA);
    strb.readActive = ~csS & (st == F_RD);
    strb.syncLow    = ~synS;
  end

  assign csActive = ~csS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pdCnt <= '0;
    else if (synS) pdCnt <= '0;
    else if (pdCnt != PD_LIM) pdCnt <= pdCnt + 1'b1;
  end

  assign powerDown = ~synS & (pdCnt == PD_LIM);

endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_regfile_pkg::*;
#(
  parameter logic [7:0] ID_VALUE = 8'h50
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       strb,
  input  logic             resWr,
  input  logic [REG_W-1:0] resData,
  input  logic [3:0]       resChan,
  input  logic             resErr,
  input  logic             resNoRef,
  input  logic [GPO_N-1:0] gpioIn,
  output logic [REG_W-1:0] modeReg,
  output logic [REG_W-1:0] cfgReg,
  output logic [REG_W-1:0] offsetReg,
  output logic [REG_W-1:0] gainReg,
  output logic [7:0]       gpoReg,
  output logic [GPO_N-1:0] gpoOe,
  output logic [7:0]       statusByte,
  output logic             doutVal
);

  logic [REG_W-1:0] dataQ;
  logic [3:0] chdQ;
  logic errQ, norefQ, drdyN, txBit;
  logic [TX_W-1:0] txSh, rdVal;
  logic calWrOk, parity;
  logic [GPO_N-1:0] pinRead;

  assign calWrOk = (modeReg[23:22] == 2'b01);
  assign parity  = modeReg[13] & (^dataQ);
  assign statusByte = {drdyN, errQ, norefQ, parity, chdQ};

  for (genvar g = 0; g < GPO_N; g++) begin : g_pin
    assign gpoOe[g]   = gpoReg[4 + g/2];
    assign pinRead[g] = gpoOe[g] ? gpioIn[g] : gpoReg[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg <= MODE_RST;
      cfgReg <= CFG_RST;
      offsetReg <= OFS_RST;
      gainReg <= GAIN_RST;
      gpoReg <= '0;
    end else if (strb.wrEn) begin
      case (strb.addr)
        A_MODE: modeReg <= strb.wrData & MODE_KEEP;
        A_CFG:  cfgReg <= strb.wrData & CFG_KEEP;
        A_GPO:  gpoReg <= strb.wrData[7:0] & GPO_KEEP;
        A_OFS:  if (calWrOk) offsetReg <= strb.wrData;
        A_GAIN: if (calWrOk) gainReg <= strb.wrData;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      chdQ <= '0;
      errQ <= 1'b0;
      norefQ <= 1'b0;
      drdyN <= 1'b1;
    end else if (resWr) begin
      dataQ <= resData;
      chdQ <= resChan;
      errQ <= resErr;
      norefQ <= resNoRef & cfgReg[6];
      drdyN <= 1'b0;
    end else if (strb.dataRdDone) begin
      drdyN <= 1'b1;
    end
  end

  always_comb begin
    case (strb.addr)
      A_STAT: rdVal = {statusByte, 24'h0};
      A_MODE: rdVal = {modeReg, 8'h0};
      A_CFG:  rdVal = {cfgReg, 8'h0};
      A_DATA: rdVal = modeReg[20] ? {dataQ, statusByte} : {dataQ, 8'h0};
      A_ID:   rdVal = {ID_VALUE, 24'h0};
      A_GPO:  rdVal = {gpoReg[7:4], pinRead, 24'h0};
      A_OFS:  rdVal = {offsetReg, 8'h0};
      A_GAIN: rdVal = {gainReg, 8'h0};
      default: rdVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txSh <= '0;
      txBit <= 1'b1;
    end else if (strb.loadTx) begin
      txSh <= rdVal;
    end else if (strb.shiftTx) begin
      txBit <= txSh[TX_W-1];
      txSh <= {txSh[TX_W-2:0], 1'b0};
    end
  end

  assign doutVal = strb.syncLow ? 1'b1 : (strb.readActive ? txBit : drdyN);

endmodule

// File: rtl/spi_regfile_ctrl.sv
module spi_regfile_ctrl
  import spi_regfile_pkg::*;
#(
  parameter int         PD_CYCLES = 4080,
  parameter logic [7:0] ID_VALUE  = 8'h50
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csN,
  input  logic             sclk,
  input  logic             din,
  input  logic             syncN,
  input  logic             resWr,
  input  logic [REG_W-1:0] resData,
  input  logic [3:0]       resChan,
  input  logic             resErr,
  input  logic             resNoRef,
  input  logic [GPO_N-1:0] gpioIn,
  output logic             doutVal,
  output logic             doutOe,
  output logic [REG_W-1:0] modeReg,
  output logic [REG_W-1:0] cfgReg,
  output logic [REG_W-1:0] offsetReg,
  output logic [REG_W-1:0] gainReg,
  output logic [GPO_N-1:0] gpoVal,
  output logic [GPO_N-1:0] gpoOe,
  output logic             bridgeSw,
  output logic             filterRst,
  output logic             powerDown
);

  ctrlStrobeT strb;
  logic [7:0] gpoReg;
  logic [7:0] statusByte;

  spi_frame_ctrl #(.PD_CYCLES(PD_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .syncN(syncN),
    .datusEn(modeReg[20]), .strb(strb), .csActive(doutOe), .powerDown(powerDown)
  );

  spi_reg_bank #(.ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rstN(rstN), .strb(strb), .resWr(resWr), .resData(resData),
    .resChan(resChan), .resErr(resErr), .resNoRef(resNoRef), .gpioIn(gpioIn),
    .modeReg(modeReg), .cfgReg(cfgReg), .offsetReg(offsetReg), .gainReg(gainReg),
    .gpoReg(gpoReg), .gpoOe(gpoOe), .statusByte(statusByte), .doutVal(doutVal)
  );

  assign gpoVal    = gpoReg[GPO_N-1:0];
  assign bridgeSw  = gpoReg[6];
  assign filterRst = strb.syncLow;

endmodule

// File: rtl/spi_regfile_chk.sv
module spi_regfile_chk (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        syncN,
  input logic        resWr,
  input logic        doutOe,
  input logic        doutVal,
  input logic        filterRst,
  input logic        powerDown,
  input logic [23:0] modeReg,
  input logic [23:0] offsetReg,
  input logic [23:0] gainReg,
  input logic [7:0]  statusByte
);

  logic [1:0] age;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R3
  dout_hiz_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && csN && $past(csN) && $past(csN, 2)) |-> !doutOe);

  // R12
  sync_force_chk: assert property (@(posedge clk) disable iff (!rstN)
    (age == 2'd3 && !syncN && !$past(syncN) && !$past(syncN, 2)) |-> (doutVal && filterRst));

  // R12
  pd_needs_rst_chk: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> filterRst);

  // R4
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    resWr |=> !statusByte[7]);

  // R10
  cal_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeReg[23:22] != 2'b01) |=> ($stable(offsetReg) && $stable(gainReg)));

  // R6
  parity_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeReg[13] |-> !statusByte[4]);

endmodule

bind spi_regfile_ctrl spi_regfile_chk u_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .syncN(syncN), .resWr(resWr),
  .doutOe(doutOe), .doutVal(doutVal), .filterRst(filterRst), .powerDown(powerDown),
  .modeReg(modeReg), .offsetReg(offsetReg), .gainReg(gainReg), .statusByte(statusByte)
);

// File: tb/tb_spi_regfile_ctrl.sv
module tb_spi_regfile_ctrl;

  localparam int PD = 4080;
  localparam logic [7:0] IDV = 8'h50;
  localparam int HP = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csN = 1'b1, sclk = 1'b1, din = 1'b0, syncN = 1'b1;
  logic resWr = 1'b0, resErr = 1'b0, resNoRef = 1'b0;
  logic [23:0] resData = '0;
  logic [3:0] resChan = '0;
  logic [3:0] gpioIn = 4'b0110;
  logic doutVal, doutOe, bridgeSw, filterRst, powerDown;
  logic [23:0] modeReg, cfgReg, offsetReg, gainReg;
  logic [3:0] gpoVal, gpoOe;

  int nChecks = 0;
  int nErr = 0;

  // behavioural model state
  logic [23:0] mMode = 24'h080060, mCfg = 24'h000117, mData = '0;
  logic [23:0] mOfs = 24'h800000, mGain = 24'h555555;
  logic [7:0] mGpo = '0;
  logic mDrdy = 1'b1, mErr = 1'b0, mNoref = 1'b0;
  logic [3:0] mChd = '0;
  logic [1:0] csHist = 2'b11, syHist = 2'b11;
  logic monOn = 1'b0;

  always #2.5 clk = ~clk;

  spi_regfile_ctrl #(.PD_CYCLES(PD), .ID_VALUE(IDV)) dut (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .syncN(syncN),
    .resWr(resWr), .resData(resData), .resChan(resChan), .resErr(resErr),
    .resNoRef(resNoRef), .gpioIn(gpioIn), .doutVal(doutVal), .doutOe(doutOe),
    .modeReg(modeReg), .cfgReg(cfgReg), .offsetReg(offsetReg), .gainReg(gainReg),
    .gpoVal(gpoVal), .gpoOe(gpoOe), .bridgeSw(bridgeSw), .filterRst(filterRst),
    .powerDown(powerDown)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  endtask

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-clock comparison of pin latency model: enable and filter reset
  always @(posedge clk) begin
    csHist <= {csHist[0], csN};
    syHist <= {syHist[0], syncN};
  end
  always @(negedge clk) begin
    if (monOn) begin
      check("R3 per-cycle enable", {39'd0, doutOe}, {39'd0, ~csHist[1]});
      check("R12 per-cycle filter reset", {39'd0, filterRst}, {39'd0, ~syHist[1]});
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nErr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  function automatic logic [7:0] mStatus();
    return {mDrdy, mErr, mNoref, mMode[13] & (^mData), mChd};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [39:0] mosi, input int nbits, input int collideBit,
                      output logic [39:0] miso);
    miso = '0;
    csN = 1'b0;
    tick(HP);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      din = mosi[nbits-1-i];
      tick(HP);
      miso = {miso[38:0], doutVal};
      sclk = 1'b1;
      if (i == collideBit) begin
        @(posedge clk); @(posedge clk); @(negedge clk);
        resWr = 1'b1;
        @(negedge clk);
        resWr = 1'b0;
        tick(HP - 2);
      end else begin
        tick(HP);
      end
    end
    tick(HP);
    csN = 1'b1;
    tick(HP);
  endtask

  task automatic rdReg(input logic [2:0] a, input int w, input int collideBit,
                       output logic [31:0] v);
    logic [39:0] mo, mi;
    mo = 40'({1'b0, 1'b1, a, 3'b000}) << w;
    xfer(mo, 8 + w, collideBit, mi);
    v = (w == 32) ? mi[31:0] : (mi[31:0] & ((32'h1 << w) - 32'h1));
  endtask

  task automatic wrRaw(input logic [7:0] cmd, input logic [23:0] val, input int w);
    logic [39:0] mo, mi;
    mo = (40'(cmd) << w) | 40'(val);
    xfer(mo, 8 + w, -1, mi);
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [23:0] val, input int w);
    wrRaw({1'b0, 1'b0, a, 3'b000}, val, w);
    case (a)
      3'd1: mMode = val & ~(24'h1 << 14) & ~(24'h1 << 12);
      3'd2: mCfg = val & ~(24'h1 << 22) & ~(24'h1 << 21) & ~(24'hF << 16) & ~(24'h1 << 5);
      3'd5: mGpo = {1'b0, val[6:0]};
      3'd6: if (mMode[23:21] == 3'b010 || mMode[23:21] == 3'b011) mOfs = val;
      3'd7: if (mMode[23:21] == 3'b010 || mMode[23:21] == 3'b011) mGain = val;
      default: ;
    endcase
  endtask

  task automatic post(input logic [23:0] d, input logic [3:0] ch, input logic e, input logic nr);
    resData = d; resChan = ch; resErr = e; resNoRef = nr;
    resWr = 1'b1;
    tick(1);
    resWr = 1'b0;
    mData = d; mChd = ch; mErr = e; mNoref = nr & mCfg[6]; mDrdy = 1'b0;
    tick(2);
  endtask

  initial begin
    logic [31:0] v;
    tick(5);
    rstN = 1'b1;
    tick(4);
    monOn = 1'b1;

    // R1 reset state at the ports
    check("R1 mode", 40'(modeReg), 40'h080060);
    check("R1 config", 40'(cfgReg), 40'h000117);
    check("R1 offset", 40'(offsetReg), 40'h800000);
    check("R1 gain", 40'(gainReg), 40'h555555);
    check("R1 outputs", {32'd0, gpoOe, bridgeSw, powerDown, filterRst, doutOe}, 40'd0);
    rdReg(3'd0, 8, -1, v);  check("R1 status read", 40'(v), 40'h80);
    rdReg(3'd1, 24, -1, v); check("R2 mode read", 40'(v), 40'h080060);
    rdReg(3'd2, 24, -1, v); check("R2 config read", 40'(v), 40'h000117);
    rdReg(3'd4, 8, -1, v);  check("R8 id read", 40'(v), 40'(IDV));

    // R3 ready flag on DOUT while selected and idle
    csN = 1'b0; tick(5);
    check("R3 idle dout no result", {39'd0, doutVal}, {39'd0, mDrdy});
    csN = 1'b1; tick(5);

    // R4 result update
    post(24'h123456, 4'd5, 1'b1, 1'b1);
    csN = 1'b0; tick(5);
    check("R3 R4 idle dout after result", {39'd0, doutVal}, 40'd0);
    csN = 1'b1; tick(5);
    rdReg(3'd0, 8, -1, v); check("R4 status", 40'(v), 40'(mStatus()));

    // R9 reserved mode bits, R6 parity
    wrReg(3'd1, 24'h08F060, 24);
    check("R9 mode reserved", 40'(modeReg), 40'(mMode));
    rdReg(3'd0, 8, -1, v); check("R6 parity odd", 40'(v), 40'(mStatus()));

    // R5 result read sets ready flag
    rdReg(3'd3, 24, -1, v); check("R5 data read", 40'(v), 40'(mData));
    mDrdy = 1'b1;
    rdReg(3'd0, 8, -1, v); check("R5 status after read", 40'(v), 40'(mStatus()));

    // R7 status appended
    wrReg(3'd1, 24'h18A060, 24);
    post(24'h000003, 4'd2, 1'b0, 1'b0);
    rdReg(3'd3, 32, -1, v); check("R7 data plus status", 40'(v), 40'({mData, mStatus()}));
    mDrdy = 1'b1;
    rdReg(3'd0, 8, -1, v); check("R7 status after", 40'(v), 40'(mStatus()));

    // R5 collision: update in the same cycle as the last read bit
    post(24'h0000AA, 4'd3, 1'b0, 1'b0);
    resData = 24'h000007; resChan = 4'd6; resErr = 1'b0; resNoRef = 1'b0;
    rdReg(3'd3, 32, 39, v);
    check("R5 collision snapshot", 40'(v), 40'({mData, mStatus()}));
    mData = 24'h000007; mChd = 4'd6; mDrdy = 1'b0;
    rdReg(3'd0, 8, -1, v); check("R5 collision update wins", 40'(v), 40'(mStatus()));

    // R12 sync low while selected and ready flag is 0
    csN = 1'b0; tick(5);
    check("R3 idle dout before sync", {39'd0, doutVal}, 40'd0);
    syncN = 1'b0; tick(5);
    check("R12 dout forced", {39'd0, doutVal}, 40'd1);
    check("R12 filter reset", {39'd0, filterRst}, 40'd1);
    tick(PD - 20);
    check("R12 no early powerdown", {39'd0, powerDown}, 40'd0);
    tick(40);
    check("R12 powerdown", {39'd0, powerDown}, 40'd1);
    syncN = 1'b1; tick(5);
    check("R12 release", {38'd0, powerDown, filterRst}, 40'd0);
    check("R12 dout back", {39'd0, doutVal}, 40'd0);
    csN = 1'b1; tick(5);

    // R10 calibration words locked outside idle/sleep
    wrReg(3'd6, 24'h00ABCD, 24);
    wrReg(3'd7, 24'h123456, 24);
    check("R10 offset locked", 40'(offsetReg), 40'(mOfs));
    check("R10 gain locked", 40'(gainReg), 40'(mGain));
    wrReg(3'd1, 24'h58A060, 24);
    wrReg(3'd6, 24'h00ABCD, 24);
    wrReg(3'd7, 24'h123456, 24);
    check("R10 offset written", 40'(offsetReg), 40'(mOfs));
    rdReg(3'd7, 24, -1, v); check("R10 gain read", 40'(v), 40'(mGain));

    // R8 read-only indices
    wrReg(3'd0, 24'h0000FF, 8);
    wrReg(3'd4, 24'h000000, 8);
    wrReg(3'd3, 24'hFFFFFF, 24);
    rdReg(3'd0, 8, -1, v); check("R8 status unchanged", 40'(v), 40'(mStatus()));
    rdReg(3'd4, 8, -1, v); check("R8 id unchanged", 40'(v), 40'(IDV));
    rdReg(3'd3, 32, -1, v); check("R8 data unchanged", 40'(v), 40'({mData, mStatus()}));
    mDrdy = 1'b1;

    // R9 config reserved bits, R4 no-reference gated by config bit 6
    wrReg(3'd2, 24'hFFFFFF, 24);
    check("R9 config reserved", 40'(cfgReg), 40'(mCfg));
    post(24'h000001, 4'd1, 1'b0, 1'b1);
    rdReg(3'd0, 8, -1, v); check("R4 noref gated on", 40'(v), 40'(mStatus()));

    // R11 general-purpose outputs
    wrReg(3'd5, 24'h0000FA, 8);
    check("R11 pins both pairs", {32'd0, gpoOe, gpoVal}, {32'd0, 4'b1111, mGpo[3:0]});
    check("R11 bridge on", {39'd0, bridgeSw}, 40'd1);
    rdReg(3'd5, 8, -1, v); check("R11 readback pins", 40'(v), 40'({mGpo[7:4], gpioIn}));
    wrReg(3'd5, 24'h00002A, 8);
    check("R11 upper pair only", {36'd0, gpoOe}, 40'b1100);
    rdReg(3'd5, 8, -1, v);
    check("R11 mixed readback", 40'(v), 40'({mGpo[7:4], gpioIn[3:2], mGpo[1:0]}));
    check("R11 bridge off", {39'd0, bridgeSw}, 40'd0);

    // R2 malformed commands are ignored
    wrRaw(8'h88, 24'h000000, 24);
    check("R2 bit7 command ignored", 40'(modeReg), 40'(mMode));
    wrRaw(8'h09, 24'h000000, 24);
    check("R2 low bits command ignored", 40'(modeReg), 40'(mMode));

    finishRun();
  end

endmodule